// File: doc/BRIEF.md
# Register Write Permission Guard

This block stands in front of a power-controller register bank and rules on each incoming write. A write carries the privilege level of its master (user or privileged), its security state (secure or non-secure), a 4-bit domain identifier and the class of the register it targets. The guard answers each write with either a grant pulse or an access-error pulse in the following cycle. The protected registers, and the handling of the granted data, stay outside the block.

The guard also holds its own permission word. The word has two enables, one for user-mode writers and one for non-secure writers, and a four-bit domain whitelist. Three sticky lock bits protect it. The first freezes the two enables. The second freezes the whitelist. The third blocks every write to the configuration class of registers, which holds the mode-to-setpoint mappings and the standby request enables. A lock bit can only be set by a write, and only reset clears it. The permission word is itself a register of the bank, in its own class, so the same checks apply to writes to it. The word is always visible on a read-back port.

Top module: `reg_write_guard`

## Requirements
- R1: After reset the read-back word is 0x0000_0100: both enables are clear, only domain 0 is whitelisted and all locks are clear. Neither grant nor access error is asserted.
- R2: When bit 0 (user enable) is clear, a write with req_user=1 is denied. When bit 0 is set, user-mode writes pass this check.
- R3: When bit 1 (non-secure enable) is clear, a write with req_nsec=1 is denied. When bit 1 is set, non-secure writes pass this check.
- R4: A write from domain d (d < 4) passes only if whitelist bit 8+d is set. Domains 4 to 15 are always denied.
- R5: While bit 20 (configuration lock) is set, every write with req_class=1 (configuration class) is denied. Classes 0, 2 and 3 are not affected by this lock.
- R6: A granted write with req_class=0 updates the permission word. While bit 4 is set, bits 1:0 keep their value.
- R7: While bit 12 is set, whitelist bits 11:8 keep their value.
- R8: Bits 4, 12 and 20 are sticky. A granted write of 1 sets them, a write of 0 leaves them set, and only reset clears them.
- R9: Each write (req_valid=1, req_write=1) is answered one cycle later by exactly one of grant or acc_err, each high for that one cycle. A denied write changes no state.
- R10: Reserved bits (all bits other than 0, 1, 4, 8 to 12 and 20) read as zero and ignore writes.
- R11: A cycle without a write (req_valid=0 or req_write=0) produces neither grant nor acc_err, and it leaves the permission word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | 1 = user-mode master, 0 = privileged |
| req_nsec | input | 1 | 1 = non-secure master, 0 = secure |
| req_domain | input | DOM_W | Domain identifier of the master |
| req_class | input | 2 | Target class: 0 permission word, 1 configuration, 2/3 general |
| req_wdata | input | 32 | Write data (used when class is 0) |
| grant | output | 1 | One-cycle pulse: previous write accepted |
| acc_err | output | 1 | One-cycle pulse: previous write denied |
| perm_rdata | output | 32 | Current permission word |

## Verification
The bench goes after the lock interactions. A guard that lets a zero write clear a lock would let a locked whitelist or enable pair change again. A guard that applies the configuration lock to every class would deny general writes. Domain identifiers 4 to 15 are probed on purpose, because a guard that indexes the whitelist with truncated bits would wrongly grant domain 4 or 8 as if it were domain 0. The bench also checks that a denied write to the permission word from an unwhitelisted or unprivileged master leaves the word untouched, and that a mid-run reset clears every lock. Any of these faults shows up as a wrong read-back value or a wrong grant or error pulse.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned WL_N    = 4;
  localparam int unsigned B_USER  = 0;
  localparam int unsigned B_NSEC  = 1;
  localparam int unsigned B_LKEN  = 4;
  localparam int unsigned B_WL    = 8;
  localparam int unsigned B_LKWL  = 12;
  localparam int unsigned B_LKCFG = 20;

  localparam logic [REG_W-1:0] EN_MASK   = (32'h1 << B_USER) | (32'h1 << B_NSEC);
  localparam logic [REG_W-1:0] WL_MASK   = 32'hF << B_WL;
  localparam logic [REG_W-1:0] LOCK_MASK = (32'h1 << B_LKEN) | (32'h1 << B_LKWL) | (32'h1 << B_LKCFG);
  localparam logic [REG_W-1:0] RST_WORD  = 32'h1 << B_WL;

  typedef enum logic [1:0] {
    CLS_PERM = 2'd0,
    CLS_CFG  = 2'd1,
    CLS_GEN  = 2'd2,
    CLS_AUX  = 2'd3
  } reg_class_e;
endpackage

// File: rtl/guard_decide.sv
module guard_decide
  import guard_pkg::*;
#(
  parameter int unsigned DOM_W = 4
) (
  input  logic             user_i,
  input  logic             nsec_i,
  input  logic [DOM_W-1:0] dom_i,
  input  logic [1:0]       cls_i,
  input  logic [REG_W-1:0] perm_i,
  output logic             ok_o
);
  logic [WL_N-1:0] dom_hit;
  logic priv_ok, sec_ok, dom_ok, cfg_ok;

  // One comparator per whitelist entry; full-width compare so high IDs never alias
  for (genvar i = 0; i < WL_N; i++) begin : g_dom
    assign dom_hit[i] = perm_i[B_WL + i] && (dom_i == DOM_W'(i));
  end

  always_comb begin
    priv_ok = !user_i || perm_i[B_USER];
    sec_ok  = !nsec_i || perm_i[B_NSEC];
    dom_ok  = |dom_hit;
    cfg_ok  = !((cls_i == CLS_CFG) && perm_i[B_LKCFG]);
    ok_o    = priv_ok && sec_ok && dom_ok && cfg_ok;
  end
endmodule

// File: rtl/guard_permreg.sv
module guard_permreg
  import guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] perm_o
);
  logic [REG_W-1:0] perm_q;
  logic [REG_W-1:0] free_mask;
  logic [REG_W-1:0] perm_d;

  always_comb begin
    free_mask = '0;
    if (!perm_q[B_LKEN]) free_mask = free_mask | EN_MASK;
    if (!perm_q[B_LKWL]) free_mask = free_mask | WL_MASK;
    // unlocked fields take new data; lock bits may only go from 0 to 1
    perm_d = (perm_q & ~free_mask) | (wdata_i & free_mask) | (wdata_i & LOCK_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst)       perm_q <= RST_WORD;
    else if (we_i) perm_q <= perm_d;
  end

  assign perm_o = perm_q;
endmodule

// File: rtl/guard_resp.sv
module guard_resp (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  input  logic ok_i,
  output logic grant_o,
  output logic err_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      grant_o <= fire_i && ok_i;
      err_o   <= fire_i && !ok_i;
    end
  end
endmodule

// File: rtl/reg_write_guard.sv
module reg_write_guard
  import guard_pkg::*;
#(
  parameter int unsigned DOM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_user,
  input  logic             req_nsec,
  input  logic [DOM_W-1:0] req_domain,
  input  logic [1:0]       req_class,
  input  logic [31:0]      req_wdata,
  output logic             grant,
  output logic             acc_err,
  output logic [31:0]      perm_rdata
);
  logic fire, ok, perm_we;
  logic [REG_W-1:0] perm;

  assign fire    = req_valid && req_write;
  assign perm_we = fire && ok && (req_class == CLS_PERM);

  guard_decide #(.DOM_W(DOM_W)) u_decide (
    .user_i (req_user),
    .nsec_i (req_nsec),
    .dom_i  (req_domain),
    .cls_i  (req_class),
    .perm_i (perm),
    .ok_o   (ok)
  );

  guard_permreg u_perm (
    .clk     (clk),
    .rst     (rst),
    .we_i    (perm_we),
    .wdata_i (req_wdata),
    .perm_o  (perm)
  );

  guard_resp u_resp (
    .clk     (clk),
    .rst     (rst),
    .fire_i  (fire),
    .ok_i    (ok),
    .grant_o (grant),
    .err_o   (acc_err)
  );

  assign perm_rdata = perm;
endmodule

// File: rtl/reg_write_guard_chk.sv
module reg_write_guard_chk #(
  parameter int unsigned DOM_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_write,
  input logic [DOM_W-1:0] req_domain,
  input logic [1:0]       req_class,
  input logic             grant,
  input logic             acc_err,
  input logic [31:0]      perm_rdata
);
  assert_one_answer_R9: assert property (@(posedge clk) disable iff (rst)
    !(grant && acc_err));

  assert_answer_follows_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> (grant || acc_err));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> (!grant && !acc_err && $stable(perm_rdata)));

  assert_high_domain_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && (req_domain >= DOM_W'(4))) |=> acc_err);

  assert_cfg_lock_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && (req_class == 2'd1) && perm_rdata[20]) |=> acc_err);

  assert_en_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    perm_rdata[4] |=> $stable(perm_rdata[1:0]));

  assert_wl_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    perm_rdata[12] |=> $stable(perm_rdata[11:8]));

  assert_locks_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (perm_rdata[4] || perm_rdata[12] || perm_rdata[20]) |=>
      ((perm_rdata[4] || !$past(perm_rdata[4])) &&
       (perm_rdata[12] || !$past(perm_rdata[12])) &&
       (perm_rdata[20] || !$past(perm_rdata[20]))));

  assert_denied_no_change_R9: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> $stable(perm_rdata));

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (perm_rdata & 32'hFFEF_E0EC) == 32'h0);
endmodule

bind reg_write_guard reg_write_guard_chk #(.DOM_W(DOM_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_domain (req_domain),
  .req_class  (req_class),
  .grant      (grant),
  .acc_err    (acc_err),
  .perm_rdata (perm_rdata)
);

// File: tb/sim_reg_write_guard.sv
`timescale 1ns/1ps
module sim_reg_write_guard;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_user, req_nsec;
  logic [3:0]  req_domain;
  logic [1:0]  req_class;
  logic [31:0] req_wdata;
  logic        grant, acc_err;
  logic [31:0] perm_rdata;

  int unsigned n_run = 0;
  int unsigned n_fail = 0;
  logic [31:0] m_perm;
  logic        finished = 1'b0;

  always #4 clk = ~clk;

  reg_write_guard #(.DOM_W(4)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_user(req_user), .req_nsec(req_nsec), .req_domain(req_domain),
    .req_class(req_class), .req_wdata(req_wdata), .grant(grant),
    .acc_err(acc_err), .perm_rdata(perm_rdata)
  );

  function automatic logic exp_ok(logic [31:0] p, logic u, logic n, logic [3:0] d, logic [1:0] c);
    logic r;
    r = 1'b1;
    if (u && !p[0]) r = 1'b0;                 // R2
    if (n && !p[1]) r = 1'b0;                 // R3
    if (d > 4'd3) r = 1'b0;                   // R4
    else if (!p[8 + d]) r = 1'b0;
    if (c == 2'd1 && p[20]) r = 1'b0;         // R5
    return r;
  endfunction

  function automatic logic [31:0] exp_next(logic [31:0] p, logic [31:0] w);
    logic [31:0] r;
    r = p;
    if (!p[4])  r[1:0]  = w[1:0];             // R6
    if (!p[12]) r[11:8] = w[11:8];            // R7
    r[4]  = p[4]  | w[4];                     // R8
    r[12] = p[12] | w[12];
    r[20] = p[20] | w[20];
    return r;                                 // R10: nothing else written
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_perm = 32'h0000_0100;
    check("R1 perm after reset", perm_rdata, 32'h0000_0100);
    check("R1 grant after reset", {31'b0, grant}, 32'h0);
    check("R1 err after reset", {31'b0, acc_err}, 32'h0);
  endtask

  task automatic op(string tag, logic v, logic w, logic u, logic n,
                    logic [3:0] d, logic [1:0] c, logic [31:0] data);
    logic fire, ok;
    @(negedge clk);
    req_valid = v; req_write = w; req_user = u; req_nsec = n;
    req_domain = d; req_class = c; req_wdata = data;
    fire = v && w;
    ok = exp_ok(m_perm, u, n, d, c);
    if (fire && ok && c == 2'd0) m_perm = exp_next(m_perm, data);
    @(posedge clk);
    #2;
    check({tag, " grant"}, {31'b0, grant}, {31'b0, fire && ok});
    check({tag, " acc_err"}, {31'b0, acc_err}, {31'b0, fire && !ok});
    check({tag, " perm"}, perm_rdata, m_perm);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    int unsigned cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; req_valid = 0; req_write = 0; req_user = 0; req_nsec = 0;
    req_domain = 0; req_class = 0; req_wdata = 0;
    do_reset();

    // R11: reads and invalid strobes do nothing
    op("R11 read", 1, 0, 0, 0, 4'd0, 2'd0, 32'hFFFF_FFFF);
    op("R11 no valid", 0, 1, 0, 0, 4'd0, 2'd0, 32'hFFFF_FFFF);
    // R2/R3 denied at reset
    op("R2 user denied", 1, 1, 1, 0, 4'd0, 2'd2, 32'h0);
    op("R3 nsec denied", 1, 1, 0, 1, 4'd0, 2'd2, 32'h0);
    op("R9 denied perm write", 1, 1, 1, 0, 4'd0, 2'd0, 32'h0000_0F03);
    // R4 domain checks
    op("R4 dom1 denied", 1, 1, 0, 0, 4'd1, 2'd2, 32'h0);
    op("R4 dom4 denied", 1, 1, 0, 0, 4'd4, 2'd2, 32'h0);
    op("R4 dom8 denied", 1, 1, 0, 0, 4'd8, 2'd2, 32'h0);
    // R10 reserved bits ignored, open all
    op("R10 write all ones", 1, 1, 0, 0, 4'd0, 2'd0, 32'hFFEF_EFEF);
    op("R2 user granted", 1, 1, 1, 0, 4'd2, 2'd2, 32'h0);
    op("R3 nsec granted", 1, 1, 0, 1, 4'd3, 2'd1, 32'h0);
    op("R4 dom12 denied", 1, 1, 0, 0, 4'd12, 2'd2, 32'h0);
    // R6/R7 locks freeze fields
    op("R6 set en lock", 1, 1, 0, 0, 4'd0, 2'd0, 32'h0000_0F13);
    op("R6 en frozen", 1, 1, 0, 0, 4'd0, 2'd0, 32'h0000_0F00);
    op("R7 set wl lock", 1, 1, 0, 0, 4'd0, 2'd0, 32'h0000_1500);
    op("R7 wl frozen", 1, 1, 0, 0, 4'd0, 2'd0, 32'h0000_0F00);
    op("R4 dom1 now denied", 1, 1, 0, 0, 4'd1, 2'd2, 32'h0);
    // R5 config lock
    op("R5 cfg before lock", 1, 1, 0, 0, 4'd0, 2'd1, 32'h0);
    op("R5 set cfg lock", 1, 1, 0, 0, 4'd2, 2'd0, 32'h0010_0000);
    op("R5 cfg blocked", 1, 1, 0, 0, 4'd0, 2'd1, 32'h0);
    op("R5 gen allowed", 1, 1, 0, 0, 4'd0, 2'd2, 32'h0);
    op("R5 aux allowed", 1, 1, 0, 0, 4'd2, 2'd3, 32'h0);
    // R8 zero write keeps locks
    op("R8 zero write", 1, 1, 0, 0, 4'd0, 2'd0, 32'h0);
    do_reset();   // R8: reset clears locks

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] dat;
      logic [3:0]  dd;
      if (i % 150 == 149) do_reset();
      dat = $urandom();
      if ($urandom_range(0, 7) != 0) dat = dat & 32'hFFEF_EFEF;
      dd = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'($urandom_range(0, 3));
      op("R9 random", $urandom_range(0, 7) != 0, $urandom_range(0, 5) != 0,
         1'($urandom()), 1'($urandom()), dd, 2'($urandom()), dat);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule